// File: doc/BRIEF.md
# Per-Task Banked Scratch Register File

This block holds a set of scratch registers for a microcoded processor whose data bus is wired-AND. The registers are grouped into banks, and every task of the processor keeps its own bank pointer. Register accesses go to the bank that the running task has chosen. A read puts a mask onto the bus. The processor ANDs this mask into the bus value together with the masks from all other sources. A store takes its data from the M latch and commits it in the late phase of the microcycle.

Register select 0 is special on reads. It returns the M latch, not a register, so register 0 of a bank can be written but never read. A register store drives an all-zero mask in the early phase. The bank pointer of the current task is loaded in the late phase from a three-bit bus field. When the block is configured for the large microstore, that same function strobe loads a 16-bit reset-mode register instead, and the bank pointers stay at zero.

Top module: `banked_scratch_regs`

## Requirements
- R1: When neither the read strobe nor the store strobe is active, `bus_mask` is all ones (16'hFFFF).
- R2: A read (`rd_strobe`=1, `late`=0) with nonzero `rsel` drives `bus_mask` equal to register `rsel` of the bank selected by the current `task_id`'s pointer.
- R3: A read with `rsel`=0 drives `bus_mask` equal to `m_latch`, whatever register 0 of the bank holds.
- R4: A store (`ld_strobe`=1) with `late`=0 drives `bus_mask` to all zeros.
- R5: A store with `late`=1 writes `m_latch` into register `rsel` of the current task's bank at that clock edge, and leaves `bus_mask` all ones.
- R6: A bank-select load (`bank_ld`=1, `late`=1) in the small configuration sets the current task's pointer to `bus_in[3:1]` (bits 12..14 in MSB-first numbering) modulo `N_BANKS`. All banks from 0 to `N_BANKS`-1 are reachable.
- R7: A bank-select load changes only the pointer of the current task. The pointers of all other tasks keep their value.
- R8: After reset, every task's bank pointer is 0 and `reset_mode` is 0. Register contents are not cleared.
- R9: With `LARGE_STORE`=1, a bank-select load instead copies all 16 bits of `bus_in` into `reset_mode` and leaves every bank pointer at 0. With `LARGE_STORE`=0, `reset_mode` stays 0.
- R10: A read strobe in the late phase does not drive the bus, so `bus_mask` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| task_id | input | 4 | Number of the task now running |
| rsel | input | 5 | Register select field |
| rd_strobe | input | 1 | Decoded bus-source strobe: read scratch register |
| ld_strobe | input | 1 | Decoded bus-source strobe: store M latch to scratch register |
| bank_ld | input | 1 | Decoded function strobe: load bank pointer (or reset-mode register) |
| late | input | 1 | Phase indication: 0 early, 1 late |
| bus_in | input | 16 | Current bus value |
| m_latch | input | 16 | M latch value |
| bus_mask | output | 16 | AND-mask this block contributes to the bus |
| reset_mode | output | 16 | Reset-mode register (large configuration only, else 0) |

## Verification
Two tasks point at different banks and store different values under the same register select. Reading each back shows that the bank comes from the task's own pointer and not from a shared one. A third task, left at its reset pointer, still sees the value stored before the switch, which separates a per-task load from a global one. Reads with select 0 after a store to register 0, early versus late reads, and early versus late stores show the M-latch bypass and the phase rules. A second instance in the large configuration runs the same stimulus, so its result differs from the small one exactly where the reset-mode load replaces the pointer load.

// File: rtl/scratch_pkg.sv
// Shared constants for the banked scratch register file.
// Assumes a 16-bit bus; the bank field sits at bus[3:1] (MSB-first bits 12..14).
package scratch_pkg;
    localparam int BUS_W       = 16;
    localparam int BANK_FLD_LO = 1;
    localparam int BANK_FLD_HI = 3;
    localparam int BANK_FLD_W  = BANK_FLD_HI - BANK_FLD_LO + 1;
    localparam logic [BUS_W-1:0] MASK_NONE = '1;
    localparam logic [BUS_W-1:0] MASK_ZERO = '0;
endpackage

// File: rtl/scratch_bank_ptr.sv
// Per-task bank pointers, plus the reset-mode register variant.
// Assumes loads are committed in the late phase; LARGE_STORE picks whether the
// function strobe loads the running task's pointer or the reset-mode register.
module scratch_bank_ptr
    import scratch_pkg::*;
#(
    parameter int N_TASKS     = 16,
    parameter int N_BANKS     = 8,
    parameter bit LARGE_STORE = 1'b0,
    localparam int TASK_W     = $clog2(N_TASKS),
    localparam int BANK_W     = (N_BANKS > 1) ? $clog2(N_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TASK_W-1:0] task_id,
    input  logic              bank_ld,
    input  logic              late,
    input  logic [BUS_W-1:0]  bus_in,
    output logic [BANK_W-1:0] cur_bank,
    output logic [BUS_W-1:0]  reset_mode
);
    logic [BANK_W-1:0]     ptr_q [N_TASKS];
    logic                  load_en;
    logic [BANK_FLD_W-1:0] fld;
    logic [BANK_W-1:0]     ptr_new;

    // Decode the commit condition and reduce the bus field to a legal bank.
    always_comb begin
        load_en = bank_ld && late;
        fld     = bus_in[BANK_FLD_HI:BANK_FLD_LO];
        ptr_new = BANK_W'(32'(fld) % N_BANKS);
    end

    // Pointer storage: cleared on reset, only the running task's entry loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < N_TASKS; t++) ptr_q[t] <= '0;
        end else if (load_en && !LARGE_STORE) begin
            ptr_q[task_id] <= ptr_new;
        end
    end

    // Present the running task's pointer.
    always_comb cur_bank = ptr_q[task_id];

    generate
        if (LARGE_STORE) begin : g_rmr
            logic [BUS_W-1:0] rmr_q;
            // Reset-mode register takes the whole bus word on a late load.
            always_ff @(posedge clk) begin
                if (!rst_n)       rmr_q <= '0;
                else if (load_en) rmr_q <= bus_in;
            end
            assign reset_mode = rmr_q;

            assert_rmr_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (bank_ld && late) |=> (reset_mode == $past(bus_in)));
        end else begin : g_no_rmr
            assign reset_mode = '0;
        end
    endgenerate

    assert_ptr_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cur_bank) < N_BANKS);

    assert_ptr_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_ld && late && !LARGE_STORE) |=>
        (32'(ptr_q[$past(task_id)]) == 32'($past(bus_in[BANK_FLD_HI:BANK_FLD_LO])) % N_BANKS));

    for (genvar g = 0; g < N_TASKS; g++) begin : g_keep
        assert_other_ptr_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !(bank_ld && late && !LARGE_STORE && (32'(task_id) == g)) |=> $stable(ptr_q[g]));
    end
endmodule

// File: rtl/scratch_array.sv
// Scratch register storage, N_BANKS banks of N_REGS words each.
// Assumes the write is committed at the clock edge of a late-phase store; the
// read port is combinational. Contents are deliberately not reset.
module scratch_array
    import scratch_pkg::*;
#(
    parameter int N_REGS  = 32,
    parameter int N_BANKS = 8,
    localparam int SEL_W  = $clog2(N_REGS),
    localparam int BANK_W = (N_BANKS > 1) ? $clog2(N_BANKS) : 1,
    localparam int DEPTH  = N_REGS * N_BANKS,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] bank,
    input  logic [SEL_W-1:0]  rsel,
    input  logic              wr_en,
    input  logic [BUS_W-1:0]  wr_data,
    output logic [BUS_W-1:0]  rd_data
);
    logic [BUS_W-1:0]  mem [DEPTH];
    logic [ADDR_W-1:0] addr;

    // Flatten bank and select into one word address.
    always_comb addr = ADDR_W'(32'(bank) * N_REGS + 32'(rsel));

    // Store the M latch word at the addressed location.
    always_ff @(posedge clk) begin
        if (wr_en) mem[addr] <= wr_data;
    end

    // Combinational read of the addressed word.
    always_comb rd_data = mem[addr];

    assert_store_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem[$past(addr)] == $past(wr_data)));
endmodule

// File: rtl/scratch_mask_mux.sv
// Forms this block's AND-mask contribution for the wired-AND bus.
// Assumes reads and stores act on the bus only in the early phase; every
// active term is ANDed, an inactive term is all ones.
module scratch_mask_mux
    import scratch_pkg::*;
#(
    parameter int SEL_W = 5
) (
    input  logic             rd_strobe,
    input  logic             ld_strobe,
    input  logic             late,
    input  logic [SEL_W-1:0] rsel,
    input  logic [BUS_W-1:0] reg_data,
    input  logic [BUS_W-1:0] m_latch,
    output logic [BUS_W-1:0] bus_mask
);
    logic [BUS_W-1:0] rd_term;
    logic [BUS_W-1:0] ld_term;

    // Combine the read term (M bypass on select 0) with the store term.
    always_comb begin
        rd_term = MASK_NONE;
        if (rd_strobe && !late) rd_term = (rsel == '0) ? m_latch : reg_data;
        ld_term = (ld_strobe && !late) ? MASK_ZERO : MASK_NONE;
        bus_mask = rd_term & ld_term;
    end
endmodule

// File: rtl/banked_scratch_regs.sv
// Top of the per-task banked scratch register file.
// Assumes decoded strobes are valid for the whole microcycle and `late` marks
// the half of the cycle whose clock edge commits stores and pointer loads.
module banked_scratch_regs
    import scratch_pkg::*;
#(
    parameter int N_TASKS     = 16,
    parameter int N_REGS      = 32,
    parameter int N_BANKS     = 8,
    parameter bit LARGE_STORE = 1'b0,
    localparam int TASK_W     = $clog2(N_TASKS),
    localparam int SEL_W      = $clog2(N_REGS),
    localparam int BANK_W     = (N_BANKS > 1) ? $clog2(N_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TASK_W-1:0] task_id,
    input  logic [SEL_W-1:0]  rsel,
    input  logic              rd_strobe,
    input  logic              ld_strobe,
    input  logic              bank_ld,
    input  logic              late,
    input  logic [BUS_W-1:0]  bus_in,
    input  logic [BUS_W-1:0]  m_latch,
    output logic [BUS_W-1:0]  bus_mask,
    output logic [BUS_W-1:0]  reset_mode
);
    logic [BANK_W-1:0] cur_bank;
    logic [BUS_W-1:0]  reg_data;
    logic              store_en;

    // Stores commit only in the late phase.
    always_comb store_en = ld_strobe && late;

    scratch_bank_ptr #(
        .N_TASKS(N_TASKS), .N_BANKS(N_BANKS), .LARGE_STORE(LARGE_STORE)
    ) u_ptr (
        .clk(clk), .rst_n(rst_n), .task_id(task_id), .bank_ld(bank_ld),
        .late(late), .bus_in(bus_in), .cur_bank(cur_bank), .reset_mode(reset_mode)
    );

    scratch_array #(.N_REGS(N_REGS), .N_BANKS(N_BANKS)) u_arr (
        .clk(clk), .rst_n(rst_n), .bank(cur_bank), .rsel(rsel),
        .wr_en(store_en), .wr_data(m_latch), .rd_data(reg_data)
    );

    scratch_mask_mux #(.SEL_W(SEL_W)) u_mux (
        .rd_strobe(rd_strobe), .ld_strobe(ld_strobe), .late(late), .rsel(rsel),
        .reg_data(reg_data), .m_latch(m_latch), .bus_mask(bus_mask)
    );

    assert_idle_all_ones_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_strobe && !ld_strobe) |-> (bus_mask == MASK_NONE));

    assert_sel0_gives_m_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !late && !ld_strobe && rsel == '0) |-> (bus_mask == m_latch));

    assert_early_store_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_strobe && !late) |-> (bus_mask == MASK_ZERO));

    assert_late_read_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (late && !(ld_strobe && !late)) |-> (bus_mask == MASK_NONE));
endmodule

// File: tb/sim_banked_scratch_regs.sv
module sim_banked_scratch_regs;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  task_id = '0;
    logic [4:0]  rsel = '0;
    logic        rd_strobe = 1'b0, ld_strobe = 1'b0, bank_ld = 1'b0, late = 1'b0;
    logic [15:0] bus_in = 16'hFFFF, m_latch = '0;
    logic [15:0] bus_mask, reset_mode, bus_mask_l, reset_mode_l;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    banked_scratch_regs u0 (
        .clk(clk), .rst_n(rst_n), .task_id(task_id), .rsel(rsel),
        .rd_strobe(rd_strobe), .ld_strobe(ld_strobe), .bank_ld(bank_ld), .late(late),
        .bus_in(bus_in), .m_latch(m_latch), .bus_mask(bus_mask), .reset_mode(reset_mode)
    );

    banked_scratch_regs #(.LARGE_STORE(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .task_id(task_id), .rsel(rsel),
        .rd_strobe(rd_strobe), .ld_strobe(ld_strobe), .bank_ld(bank_ld), .late(late),
        .bus_in(bus_in), .m_latch(m_latch), .bus_mask(bus_mask_l), .reset_mode(reset_mode_l)
    );

    task automatic check16(input string req, input string what,
                           input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic go_idle();
        rd_strobe = 0; ld_strobe = 0; bank_ld = 0; late = 0;
        bus_in = 16'hFFFF; m_latch = 16'h0000;
    endtask

    // One-cycle late-phase store; committed at the posedge inside.
    task automatic store(input logic [3:0] t, input logic [4:0] s, input logic [15:0] v);
        @(negedge clk); go_idle();
        task_id = t; rsel = s; ld_strobe = 1; late = 1; m_latch = v;
        @(negedge clk); go_idle();
    endtask

    // Late-phase bank-select load with the field placed at bus[3:1].
    task automatic load_bank(input logic [3:0] t, input logic [15:0] word);
        @(negedge clk); go_idle();
        task_id = t; bank_ld = 1; late = 1; bus_in = word;
        @(negedge clk); go_idle();
    endtask

    // Early-phase read; leaves the strobes set for the caller to sample.
    task automatic read_setup(input logic [3:0] t, input logic [4:0] s, input logic [15:0] m);
        @(negedge clk); go_idle();
        task_id = t; rsel = s; rd_strobe = 1; m_latch = m;
        #1;
    endtask

    task automatic t_reset();
        check16("R1", "idle mask after reset", bus_mask, 16'hFFFF);
        check16("R8", "reset_mode after reset", reset_mode, 16'h0000);
        check16("R8", "large reset_mode after reset", reset_mode_l, 16'h0000);
        // Both tasks start at bank 0: store from task 3, read from task 5.
        store(4'd3, 5'd7, 16'hA5C3);
        read_setup(4'd5, 5'd7, 16'h0000);
        check16("R8", "pointers share bank 0 after reset", bus_mask, 16'hA5C3);
        go_idle();
    endtask

    task automatic t_store_phases();
        @(negedge clk); go_idle();
        task_id = 4'd3; rsel = 5'd7; ld_strobe = 1; late = 0; m_latch = 16'h1357;
        #1;
        check16("R4", "early store mask", bus_mask, 16'h0000);
        late = 1;
        #1;
        check16("R5", "late store mask", bus_mask, 16'hFFFF);
        @(negedge clk); go_idle();
        read_setup(4'd3, 5'd7, 16'h0000);
        check16("R5", "stored M value read back", bus_mask, 16'h1357);
        late = 1;
        #1;
        check16("R10", "late read mask", bus_mask, 16'hFFFF);
        go_idle();
    endtask

    task automatic t_bank_select();
        load_bank(4'd1, 16'hFFF1 | (16'd2 << 1));
        load_bank(4'd2, 16'h0000 | (16'd5 << 1));
        store(4'd1, 5'd9, 16'h1234);
        store(4'd2, 5'd9, 16'hABCD);
        read_setup(4'd1, 5'd9, 16'h0000);
        check16("R2", "task1 bank2 sel9", bus_mask, 16'h1234);
        read_setup(4'd2, 5'd9, 16'h0000);
        check16("R6", "task2 bank5 sel9", bus_mask, 16'hABCD);
        read_setup(4'd3, 5'd7, 16'h0000);
        check16("R7", "task3 still on bank 0", bus_mask, 16'h1357);
        go_idle();
    endtask

    task automatic t_top_bank();
        store(4'd3, 5'd31, 16'h0F0F);
        load_bank(4'd4, 16'hFFF1 | (16'd7 << 1));
        store(4'd4, 5'd31, 16'hF0F0);
        read_setup(4'd4, 5'd31, 16'h0000);
        check16("R6", "task4 bank7 sel31", bus_mask, 16'hF0F0);
        read_setup(4'd3, 5'd31, 16'h0000);
        check16("R7", "bank0 sel31 untouched", bus_mask, 16'h0F0F);
        go_idle();
    endtask

    task automatic t_sel0();
        store(4'd1, 5'd0, 16'h7777);
        read_setup(4'd1, 5'd0, 16'h5A5A);
        check16("R3", "select 0 gives M latch", bus_mask, 16'h5A5A);
        m_latch = 16'h00FF;
        #1;
        check16("R3", "select 0 follows M latch", bus_mask, 16'h00FF);
        go_idle();
    endtask

    task automatic t_large_cfg();
        load_bank(4'd6, 16'hFFF7);
        check16("R9", "small config reset_mode stays 0", reset_mode, 16'h0000);
        check16("R9", "large config reset_mode loaded", reset_mode_l, 16'hFFF7);
        store(4'd6, 5'd12, 16'h1111);
        store(4'd7, 5'd12, 16'h2222);
        read_setup(4'd6, 5'd12, 16'h0000);
        check16("R6", "small config task6 on bank 3", bus_mask, 16'h1111);
        check16("R9", "large config pointers stay 0", bus_mask_l, 16'h2222);
        go_idle();
        #1;
        check16("R1", "idle mask at end", bus_mask, 16'hFFFF);
    endtask

    initial begin
        go_idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        t_reset();
        t_store_phases();
        t_bank_select();
        t_top_bank();
        t_sel0();
        t_large_cfg();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule